// File: doc/BRIEF.md
# UART Receive FIFO with Character Timeout

This block holds received serial characters until software collects them. A deserializer hands it one byte per strobe, or a break strobe. Software sees a head-of-queue byte on each receive-buffer read. In queued mode the bytes sit in a 16-entry first-in first-out store. In direct mode they sit in a single holding register. The block reports data-ready, overrun and break status. It also flags when the fill level reaches a programmable trigger threshold.

The block runs a character timeout while the queue is enabled. The timer restarts whenever a character arrives, and whenever a read leaves data behind. The window is four character times, where one character time is a count of clock ticks supplied on an input port. When the window expires and data is still waiting, the block raises a timeout flag. The next read clears it.

A one-byte configuration write controls the block. Bit 0 enables the queue. Bit 1 flushes the receive side. Bits 7:6 choose the trigger threshold. The interrupt encoder, the transmitter and the deserializer sit outside this block.

Top module: `uart_rxq`

## Requirements
- R1: After reset: `level_o`=0; `data_ready_o`, `overrun_o`, `break_o`, `timeout_o` and `trig_hit_o` are 0; the queue is disabled and the trigger selection is 00.
- R2: With config bit 0 set, received bytes come out of `rd_data_o` in arrival order, one per `rd_i` cycle. `level_o` gives the stored count and `data_ready_o` is high exactly when the count is non-zero.
- R3: With the queue full (16 entries), an incoming byte is dropped and `overrun_o` is set. The stored bytes and their order stay as they were.
- R4: A read of the empty queue returns 0x00 on `rd_data_o` and leaves the level at 0.
- R5: Config bits 7:6 select the trigger threshold: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. They are loaded only by a write with bit 0 set. `trig_hit_o` is high when the level is at or above the threshold. In direct mode `trig_hit_o` follows `data_ready_o`.
- R6: A config write that toggles bit 0, or that has bit 1 set, does the following: it empties the queue, drops the holding register, clears data-ready, break and timeout, and stops the timer. `overrun_o` is kept.
- R7: In queued mode, each arriving character loads a window of 4×`char_ticks_i` clocks, where `char_ticks_i` is at least 1. If no read comes, `timeout_o` rises exactly that many cycles after the arrival edge, provided data is still stored.
- R8: Any `rd_i` clears `timeout_o`. A queued read that leaves data behind restarts the full window. A read that empties the queue stops the timer and clears `break_o`.
- R9: A break strobe stores 0x00 in place of a data byte and sets `break_o` and data-ready.
- R10: In direct mode (bit 0 clear), each byte overwrites the holding register. A byte arriving while data-ready is set raises `overrun_o`. A read returns the register and clears data-ready and break.
- R11: `stat_rd_i` clears `overrun_o` and `break_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_break_i | input | 1 | Break detected strobe |
| char_ticks_i | input | 16 | One character time in clock ticks |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration byte (bit 0 enable, bit 1 flush, bits 7:6 threshold) |
| rd_i | input | 1 | Receive buffer read strobe |
| stat_rd_i | input | 1 | Status read strobe |
| rd_data_o | output | 8 | Byte returned for the current read |
| level_o | output | 5 | Stored byte count |
| data_ready_o | output | 1 | Data available |
| overrun_o | output | 1 | Overrun status |
| break_o | output | 1 | Break status |
| trig_hit_o | output | 1 | Level at or above threshold |
| timeout_o | output | 1 | Character timeout pending |

## Verification
The assertions rely on a few input conditions. `char_ticks_i` must be non-zero whenever the timer is loaded. A flushing configuration write takes precedence over any strobe in the same cycle. An overrun check holds only when no read coincides with the dropped byte. The stimulus issues exactly one operation per clock: a byte, a break, a read, a status read, a config write, or nothing. It keeps `char_ticks_i` at small non-zero values, and it mixes random config writes that do and do not flush with long runs of idle cycles, so timeouts both fire and get pre-empted.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_QTR  = 2'b01,
    TRIG_HALF = 2'b10,
    TRIG_NEAR = 2'b11
  } trig_sel_e;

  // threshold scales with depth: 1, D/4, D/2, D-2 (1/4/8/14 at 16)
  function automatic int unsigned trig_level(trig_sel_e sel, int unsigned depth);
    case (sel)
      TRIG_ONE:  return 1;
      TRIG_QTR:  return depth / 4;
      TRIG_HALF: return depth / 2;
      default:   return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign head_o  = mem_q[rptr_q];
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= (wptr_q == LAST_IDX) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (rptr_q == LAST_IDX) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_CNT);
  a_r3_full_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> full_o);
  a_r3_full_keeps_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(head_o));
endmodule

// File: rtl/uart_rxq_timer.sv
module uart_rxq_timer #(
  parameter int unsigned CT_W = 16,
  localparam int unsigned TW  = CT_W + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            cancel_i,
  input  logic [CT_W-1:0] char_ticks_i,
  output logic            fire_o
);
  logic [TW-1:0] cnt_q;
  logic          arm_q;
  logic [TW-1:0] load;

  assign load   = {char_ticks_i, 2'b00};  // four character times
  assign fire_o = arm_q && (cnt_q == TW'(1)) && !restart_i && !cancel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else if (restart_i) begin
      arm_q <= 1'b1;
      cnt_q <= load;
    end else if (cancel_i) begin
      arm_q <= 1'b0;
    end else if (arm_q) begin
      if (cnt_q == TW'(1)) arm_q <= 1'b0;
      else                 cnt_q <= cnt_q - 1'b1;
    end
  end

  a_r7_ticks_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |-> (char_ticks_i != '0));
  a_r7_single_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned CT_W  = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rx_valid_i,
  input  logic [DW-1:0]   rx_data_i,
  input  logic            rx_break_i,
  input  logic [CT_W-1:0] char_ticks_i,
  input  logic            cfg_we_i,
  input  logic [7:0]      cfg_wdata_i,
  input  logic            rd_i,
  input  logic            stat_rd_i,
  output logic [DW-1:0]   rd_data_o,
  output logic [CW-1:0]   level_o,
  output logic            data_ready_o,
  output logic            overrun_o,
  output logic            break_o,
  output logic            trig_hit_o,
  output logic            timeout_o
);
  logic            fifo_en_q;
  trig_sel_e       trig_q;
  logic [DW-1:0]   hold_q;
  logic            hold_dr_q, brk_q, ovr_q, to_q;
  logic            cfg_flush, byte_in, q_push, q_pop, last_pop;
  logic [DW-1:0]   in_byte, head;
  logic [CW-1:0]   count;
  logic            full, empty, fire, t_restart, t_cancel;
  logic [CW-1:0]   thresh;

  assign cfg_flush = cfg_we_i && ((cfg_wdata_i[0] != fifo_en_q) || cfg_wdata_i[1]);
  assign byte_in   = (rx_valid_i || rx_break_i) && !cfg_flush;
  assign in_byte   = rx_break_i ? '0 : rx_data_i;
  assign q_push    = fifo_en_q && byte_in;
  assign q_pop     = fifo_en_q && rd_i && !cfg_flush;
  assign last_pop  = q_pop && (count <= CW'(1));

  uart_rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (cfg_flush),
    .push_i  (q_push),
    .data_i  (in_byte),
    .pop_i   (q_pop),
    .head_o  (head),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  assign t_restart = q_push || (q_pop && (count > CW'(1)));
  assign t_cancel  = cfg_flush || last_pop;

  uart_rxq_timer #(.CT_W(CT_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (t_restart),
    .cancel_i     (t_cancel),
    .char_ticks_i (char_ticks_i),
    .fire_o       (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_en_q <= 1'b0;
      trig_q    <= TRIG_ONE;
    end else if (cfg_we_i) begin
      fifo_en_q <= cfg_wdata_i[0];
      if (cfg_wdata_i[0]) trig_q <= trig_sel_e'(cfg_wdata_i[7:6]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= '0;
      hold_dr_q <= 1'b0;
    end else if (cfg_flush) begin
      hold_dr_q <= 1'b0;
    end else if (!fifo_en_q && byte_in) begin
      hold_q    <= in_byte;
      hold_dr_q <= 1'b1;
    end else if (!fifo_en_q && rd_i) begin
      hold_dr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q <= 1'b0;
      ovr_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      if (rx_break_i && !cfg_flush)                       brk_q <= 1'b1;
      else if (cfg_flush || stat_rd_i || last_pop ||
               (!fifo_en_q && rd_i))                      brk_q <= 1'b0;

      if (byte_in && (fifo_en_q ? full : hold_dr_q))      ovr_q <= 1'b1;
      else if (stat_rd_i)                                 ovr_q <= 1'b0;

      if (cfg_flush || rd_i)                              to_q  <= 1'b0;
      else if (fire && fifo_en_q && !empty)               to_q  <= 1'b1;
    end
  end

  always_comb begin
    thresh = CW'(trig_level(trig_q, DEPTH));
  end

  assign rd_data_o    = fifo_en_q ? (empty ? '0 : head) : hold_q;
  assign level_o      = count;
  assign data_ready_o = fifo_en_q ? !empty : hold_dr_q;
  assign overrun_o    = ovr_q;
  assign break_o      = brk_q;
  assign timeout_o    = to_q;
  assign trig_hit_o   = fifo_en_q ? (count >= thresh) : hold_dr_q;

  a_r4_empty_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && fifo_en_q && empty) |-> (rd_data_o == '0));
  a_r6_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_flush |=> (level_o == '0) && !data_ready_o && !break_o && !timeout_o);
  a_r3_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_push && full) |=> overrun_o);
  a_r8_read_clears_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !timeout_o);
  a_r7_timeout_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> data_ready_o);
  a_r9_break_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_break_i && !cfg_flush) |=> break_o && data_ready_o);
  a_r10_hold_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_q && byte_in && hold_dr_q) |=> overrun_o);
  a_r11_status_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !byte_in) |=> !overrun_o && !break_o);
endmodule

// File: tb/uart_rxq_tb.sv
module uart_rxq_tb;
  localparam int OP_IDLE = 0, OP_RX = 1, OP_BRK = 2, OP_RD = 3, OP_STAT = 4, OP_CFG = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_break = 1'b0, cfg_we = 1'b0, rd = 1'b0, stat_rd = 1'b0;
  logic [7:0]  rx_data = '0, cfg_wdata = '0;
  logic [15:0] ct = 16'd3;
  logic [7:0]  rd_data;
  logic [4:0]  level;
  logic        dr, ovr, brk, trig, to;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_rxq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_break_i(rx_break), .char_ticks_i(ct), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .rd_i(rd), .stat_rd_i(stat_rd), .rd_data_o(rd_data), .level_o(level),
    .data_ready_o(dr), .overrun_o(ovr), .break_o(brk), .trig_hit_o(trig), .timeout_o(to)
  );

  // reference model state
  logic [7:0] m_q [16];
  int  m_cnt = 0, m_left = 0;
  bit  m_en = 0, m_ovr = 0, m_brk = 0, m_hdr = 0, m_to = 0, m_arm = 0;
  logic [1:0] m_trig = 2'b00;
  logic [7:0] m_hold = 8'h00;

  function automatic int lvl_of(logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd();
    if (m_en) return (m_cnt > 0) ? m_q[0] : 8'h00;
    return m_hold;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step(int op, logic [7:0] d);
    bit flush, restart, cancel;
    logic [7:0] b;
    flush = 0; restart = 0; cancel = 0;
    case (op)
      OP_RX, OP_BRK: begin
        b = (op == OP_BRK) ? 8'h00 : d;
        if (m_en) begin
          if (m_cnt == 16) m_ovr = 1;
          else begin m_q[m_cnt] = b; m_cnt++; end
          restart = 1;
        end else begin
          if (m_hdr) m_ovr = 1;
          m_hold = b; m_hdr = 1;
        end
        if (op == OP_BRK) m_brk = 1;
      end
      OP_RD: begin
        m_to = 0;
        if (m_en) begin
          if (m_cnt > 0) begin
            for (int i = 0; i < 15; i++) m_q[i] = m_q[i+1];
            m_cnt--;
          end
          if (m_cnt == 0) begin m_brk = 0; cancel = 1; end
          else restart = 1;
        end else begin
          m_hdr = 0; m_brk = 0;
        end
      end
      OP_STAT: begin m_ovr = 0; m_brk = 0; end
      OP_CFG: begin
        flush = (d[0] != m_en) || d[1];
        if (flush) begin m_cnt = 0; m_hdr = 0; m_brk = 0; m_to = 0; cancel = 1; end
        m_en = d[0];
        if (d[0]) m_trig = d[7:6];
      end
      default: ;
    endcase
    if (restart) begin m_arm = 1; m_left = 4 * int'(ct); end
    else if (cancel) m_arm = 0;
    else if (m_arm) begin
      if (m_left == 1) begin
        m_arm = 0;
        if (m_en && m_cnt > 0) m_to = 1;
      end else m_left--;
    end
  endtask

  task automatic check_outs(string tag);
    chk(tag, "level", int'(level), m_cnt);
    chk(tag, "data_ready", int'(dr), int'(m_en ? (m_cnt > 0) : m_hdr));
    chk(tag, "overrun", int'(ovr), int'(m_ovr));
    chk(tag, "break", int'(brk), int'(m_brk));
    chk(tag, "timeout", int'(to), int'(m_to));
    chk(tag, "trig_hit", int'(trig), int'(m_en ? (m_cnt >= lvl_of(m_trig)) : m_hdr));
  endtask

  // called at a negedge; returns at the next negedge
  task automatic do_op(int op, logic [7:0] d, string tag);
    rx_valid = (op == OP_RX);
    rx_break = (op == OP_BRK);
    rx_data  = d;
    rd       = (op == OP_RD);
    stat_rd  = (op == OP_STAT);
    cfg_we   = (op == OP_CFG);
    cfg_wdata = d;
    #1;
    if (op == OP_RD) chk(tag, "rd_data", int'(rd_data), int'(exp_rd()));
    @(posedge clk);
    model_step(op, d);
    @(negedge clk);
    rx_valid = 0; rx_break = 0; rd = 0; stat_rd = 0; cfg_we = 0;
    check_outs(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) do_op(OP_IDLE, 8'h00, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int r;
    logic [7:0] d;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_outs("R1");
    chk("R1", "rd_data_hold", int'(rd_data), 0);

    // R2 ordered read-back
    ct = 16'd3;
    do_op(OP_CFG, 8'h01, "R2");
    do_op(OP_RX, 8'hA1, "R2");
    do_op(OP_RX, 8'hB2, "R2");
    do_op(OP_RX, 8'hC3, "R2");
    do_op(OP_RD, 8'h00, "R2");
    do_op(OP_RD, 8'h00, "R2");
    do_op(OP_RD, 8'h00, "R2");

    // R3 overrun on full queue keeps contents
    for (int i = 0; i < 16; i++) do_op(OP_RX, 8'(8'h40 + i), "R3");
    do_op(OP_RX, 8'hEE, "R3");
    do_op(OP_RD, 8'h00, "R3");
    do_op(OP_STAT, 8'h00, "R11");
    for (int i = 0; i < 15; i++) do_op(OP_RD, 8'h00, "R3");

    // R4 read of empty queue
    do_op(OP_RD, 8'h00, "R4");
    do_op(OP_RD, 8'h00, "R4");

    // R5 threshold encodings
    do_op(OP_CFG, 8'h41, "R5");
    for (int i = 0; i < 4; i++) do_op(OP_RX, 8'(i), "R5");
    do_op(OP_CFG, 8'h81, "R5");
    for (int i = 0; i < 4; i++) do_op(OP_RX, 8'(i), "R5");
    do_op(OP_CFG, 8'hC1, "R5");
    for (int i = 0; i < 6; i++) do_op(OP_RX, 8'(i), "R5");

    // R6 flush via bit 1, overrun kept
    for (int i = 0; i < 3; i++) do_op(OP_RX, 8'h99, "R6");
    do_op(OP_BRK, 8'h00, "R6");
    do_op(OP_CFG, 8'h03, "R6");
    do_op(OP_CFG, 8'h01, "R6");

    // R7 timeout after 4*ct cycles
    do_op(OP_RX, 8'h11, "R7");
    idle(11, "R7");
    idle(1, "R7");
    // R8 read clears; read leaving data restarts window
    do_op(OP_RX, 8'h22, "R8");
    idle(12, "R8");
    do_op(OP_RD, 8'h00, "R8");
    idle(11, "R8");
    idle(1, "R8");
    do_op(OP_RD, 8'h00, "R8");
    idle(14, "R8");

    // R9 break pushes zero
    do_op(OP_RX, 8'h5A, "R9");
    do_op(OP_BRK, 8'h00, "R9");
    do_op(OP_RD, 8'h00, "R9");
    do_op(OP_RD, 8'h00, "R9");
    do_op(OP_BRK, 8'h00, "R11");
    do_op(OP_STAT, 8'h00, "R11");

    // R10 direct mode via toggling bit 0
    do_op(OP_CFG, 8'h00, "R10");
    do_op(OP_RX, 8'h31, "R10");
    do_op(OP_RX, 8'h32, "R10");
    do_op(OP_RD, 8'h00, "R10");
    do_op(OP_BRK, 8'h00, "R10");
    do_op(OP_RD, 8'h00, "R10");
    do_op(OP_STAT, 8'h00, "R10");

    // random mix
    ct = 16'd2;
    do_op(OP_CFG, 8'h01, "R2");
    for (int n = 0; n < 4000; n++) begin
      r = int'($urandom % 100);
      d = 8'($urandom);
      if (r < 32)      do_op(OP_RX, d, "R2");
      else if (r < 35) do_op(OP_BRK, 8'h00, "R9");
      else if (r < 58) do_op(OP_RD, 8'h00, "R8");
      else if (r < 62) do_op(OP_STAT, 8'h00, "R11");
      else if (r < 65) begin
        d[0] = ($urandom % 5) != 0;
        d[1] = ($urandom % 3) == 0;
        do_op(OP_CFG, d, "R6");
      end else do_op(OP_IDLE, 8'h00, "R7");
    end
    finish_run();
  end
endmodule